// File: doc/BRIEF.md
# Dual-controller command/data port register interface

This block is the processor-facing slave of a parallel bus. Two logical controllers, a host side and a device side, sit behind one four-port window. Each controller has a command port and a data port. The processor first writes a command byte to a command port. The low seven bits of that byte pick a register of that controller. The top bit says whether the register will be written (1) or read (0). Later accesses to the same controller's data port then move 16-bit words to or from the chosen register. The command stays in force until the next command write.

The bus is asynchronous to the core clock. The chip select, write strobe, address and write data are brought into the clock domain through a synchroniser. A three-state machine (`ST_IDLE`, `ST_WRITE`, `ST_COMMIT`) acts on each write when the write strobe rises:
- `ST_IDLE` → `ST_WRITE` when the synchronised chip select and write strobe are both low. The port number is captured on this transition.
- `ST_WRITE` tracks the write data while the strobe stays low.
- `ST_WRITE` → `ST_COMMIT` when the strobe returns high.
- `ST_COMMIT` applies the write for one cycle and returns to `ST_IDLE`.

Reads are combinational. The output bus is enabled only while chip select and read strobe are both low.

Top module: `cmd_port_regif`

## Requirements
- R1: Port decode uses address bits [1:0]: 00 host data, 01 host command, 10 device data, 11 device command. Each commit touches at most one target.
- R2: A command-port write stores the written data bits [6:0] as the register index and bit 7 as the direction (1 = write, 0 = read) for that controller only.
- R3: A data-port write under a write-direction command updates the selected register. The update takes effect after the write strobe rises.
- R4: A data-port read under a read-direction command returns the selected register on the 16-bit bus.
- R5: A data-port access whose direction differs from the stored command bit is ignored. A write leaves the register unchanged, and a read returns zero.
- R6: Command ports are write-only. A read of either one returns zero and changes nothing.
- R7: The output-enable is high only while chip select and read strobe are both low. While it is low, the output data is zero.
- R8: A write strobe while chip select is high has no effect.
- R9: A register index at or above REG_COUNT reads as zero, and writes to it are dropped.
- R10: After reset, every register is zero and both commands select register 0 for reading.
- R11: The two controllers' commands and registers are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_addr | input | 2 | Port select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_din | input | DATA_W | Write data from the bus |
| bus_dout | output | DATA_W | Read data to the bus |
| bus_doe | output | 1 | Output enable for the bus driver |

## Verification
The bench sweeps both controllers over every valid index and two indices beyond the register count, writing a distinct value to each register and reading every one back. This separates the two banks, catches index aliasing and confirms the out-of-range rule. Further patterns pair each direction with the opposite access, read the command ports, and write with chip select high. Each of these shows whether a register or the stored command was wrongly touched. A cross-controller sequence and checks of the output enable against its strobe combinations complete the patterns.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int IDX_W = 7;
    localparam int CMD_W = IDX_W + 1;

    typedef enum logic [1:0] {
        PORT_HOST_DATA = 2'b00,
        PORT_HOST_CMD  = 2'b01,
        PORT_DEV_DATA  = 2'b10,
        PORT_DEV_CMD   = 2'b11
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_COMMIT = 2'd2
    } wr_state_e;

    function automatic logic port_is_cmd(input logic [1:0] p);
        return p[0];
    endfunction

    function automatic logic port_ctrl(input logic [1:0] p);
        return p[1];
    endfunction

endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/regif_cmd_latch.sv
module regif_cmd_latch
    import regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] load_cmd,
    output logic             cmd_dir,
    output logic [IDX_W-1:0] cmd_idx
);
    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cmd_q <= '0;
        else if (load) cmd_q <= load_cmd;
    end

    assign cmd_dir = cmd_q[CMD_W-1];
    assign cmd_idx = cmd_q[IDX_W-1:0];

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmd_q)); // R2
endmodule

// File: rtl/regif_regbank.sv
module regif_regbank
    import regif_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SEL_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic [REG_COUNT-1:0][DATA_W-1:0] mem;
    logic                             in_range;
    logic [SEL_W-1:0]                 sel;

    assign in_range = int'(idx) < REG_COUNT;
    assign sel      = idx[SEL_W-1:0];

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[r] <= '0;
            else if (wr_en && in_range && int'(sel) == r)
                mem[r] <= wr_data;
        end
    end

    assign rd_data = in_range ? mem[sel] : '0;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem)); // R5
endmodule

// File: rtl/cmd_port_regif.sv
module cmd_port_regif
    import regif_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_COUNT = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);
    localparam int NUM_CTRL = 2;
    localparam int SYNC_W = 4 + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {(SYNC_W-2){1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    logic              cs_s, wr_s;
    logic [1:0]        addr_s;
    logic [DATA_W-1:0] din_s;

    regif_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_wr_n, bus_addr, bus_din}),
        .q     (sync_q)
    );
    assign {cs_s, wr_s, addr_s, din_s} = sync_q;

    wr_state_e         state_q, state_d;
    logic [1:0]        lat_port;
    logic [DATA_W-1:0] lat_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_s && !wr_s) state_d = ST_WRITE;
            ST_WRITE:  if (wr_s)           state_d = ST_COMMIT;
            ST_COMMIT:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_port <= '0;
            lat_data <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_WRITE) begin
                lat_port <= addr_s;
                lat_data <= din_s;
            end else if (state_q == ST_WRITE && !wr_s) begin
                lat_data <= din_s;
            end
        end
    end

    logic [NUM_CTRL-1:0] cmd_load, bank_wr, cmd_dir;
    logic [IDX_W-1:0]    cmd_idx [NUM_CTRL];
    logic [DATA_W-1:0]   bank_rd [NUM_CTRL];

    always_comb begin
        cmd_load = '0;
        bank_wr  = '0;
        if (state_q == ST_COMMIT) begin
            if (port_is_cmd(lat_port))
                cmd_load[port_ctrl(lat_port)] = 1'b1;
            else if (cmd_dir[port_ctrl(lat_port)])
                bank_wr[port_ctrl(lat_port)] = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        regif_cmd_latch u_cmd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cmd_load[g]),
            .load_cmd (lat_data[CMD_W-1:0]),
            .cmd_dir  (cmd_dir[g]),
            .cmd_idx  (cmd_idx[g])
        );
        regif_regbank #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (cmd_idx[g]),
            .wr_en   (bank_wr[g]),
            .wr_data (lat_data),
            .rd_data (bank_rd[g])
        );
    end

    logic [DATA_W-1:0] rd_val;
    logic              rd_ctrl;

    always_comb begin
        rd_ctrl = port_ctrl(bus_addr);
        rd_val  = '0;
        if (!port_is_cmd(bus_addr) && !cmd_dir[rd_ctrl])
            rd_val = bank_rd[rd_ctrl];
    end

    assign bus_doe  = !bus_cs_n && !bus_rd_n;
    assign bus_dout = bus_doe ? rd_val : '0;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_load, bank_wr})); // R1
    AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_s) |=> state_q == ST_IDLE); // R8
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_doe |-> bus_dout == '0); // R7
    AST_CMD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_rd_n && bus_addr[0]) |-> bus_dout == '0); // R6
endmodule

// File: tb/cmd_port_regif_tb_top.sv
module cmd_port_regif_tb_top;
    localparam int DW = 16;
    localparam int NREG = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, rd_n, wr_n;
    logic [1:0]    addr;
    logic [DW-1:0] din, dout;
    logic          doe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [DW-1:0] model [2*NREG];

    always #2.5 clk = ~clk;

    cmd_port_regif #(.DATA_W(DW), .REG_COUNT(NREG), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_addr(addr),
        .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_din(din),
        .bus_dout(dout), .bus_doe(doe)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic csv, input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); cs_n = csv; addr = a; din = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d, output logic oe);
        @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
        @(negedge clk);
        d = dout; oe = doe;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int c, input int i);
        return (c == 1 ? 16'h5A00 : 16'hC300) + 16'(i) * 16'h0101 + 16'h1;
    endfunction

    logic [DW-1:0] rv;
    logic          roe;

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
        for (int k = 0; k < 2*NREG; k++) model[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        bus_read(2'b00, rv, roe); check("R10 host reg0 after reset", rv, '0);
        check("R7 oe on read", {15'd0, roe}, 16'd1);
        bus_read(2'b10, rv, roe); check("R10 dev reg0 after reset", rv, '0);

        // R1 R3 R9: sweep writes
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NREG + 2; i++) begin
                bus_write(1'b0, c == 1 ? 2'b11 : 2'b01, 16'h0080 | 16'(i));
                bus_write(1'b0, c == 1 ? 2'b10 : 2'b00, pat(c, i));
                if (i < NREG) model[c*NREG + i] = pat(c, i);
            end
        end
        // R1 R4 R9: sweep reads
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NREG + 2; i++) begin
                bus_write(1'b0, c == 1 ? 2'b11 : 2'b01, 16'(i));
                bus_read(c == 1 ? 2'b10 : 2'b00, rv, roe);
                if (i < NREG) check("R1 R3 R4 readback", rv, model[c*NREG + i]);
                else          check("R9 out-of-range index", rv, '0);
            end
        end

        // R5 R2: read under write-direction command
        bus_write(1'b0, 2'b01, 16'h0083);
        bus_read(2'b00, rv, roe); check("R5 read under write cmd", rv, '0);
        // R5: write under read-direction command is dropped
        bus_write(1'b0, 2'b01, 16'h0003);
        bus_write(1'b0, 2'b00, 16'hFFFF);
        bus_read(2'b00, rv, roe); check("R5 write under read cmd", rv, model[3]);

        // R6: command ports read zero, no side effect
        bus_read(2'b01, rv, roe); check("R6 host cmd read", rv, '0);
        bus_read(2'b11, rv, roe); check("R6 dev cmd read", rv, '0);
        bus_read(2'b00, rv, roe); check("R6 no side effect", rv, model[3]);

        // R8: write with chip select high
        bus_write(1'b0, 2'b01, 16'h0082);
        bus_write(1'b1, 2'b00, 16'hDEAD);
        bus_write(1'b0, 2'b01, 16'h0002);
        bus_read(2'b00, rv, roe); check("R8 cs high write ignored", rv, model[2]);
        bus_write(1'b1, 2'b01, 16'h0085);
        bus_read(2'b00, rv, roe); check("R8 cs high cmd ignored", rv, model[2]);

        // R7: output enable combinations
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; addr = 2'b00;
        @(negedge clk); check("R7 rd high oe", {15'd0, doe}, 16'd0);
        check("R7 rd high dout", dout, '0);
        cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); check("R7 cs high oe", {15'd0, doe}, 16'd0);
        check("R7 cs high dout", dout, '0);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: controller independence
        bus_write(1'b0, 2'b11, 16'h0001);
        bus_write(1'b0, 2'b01, 16'h0085);
        bus_write(1'b0, 2'b00, 16'h1234);
        model[5] = 16'h1234;
        bus_read(2'b10, rv, roe); check("R11 dev cmd kept", rv, model[NREG + 1]);
        bus_write(1'b0, 2'b01, 16'h0005);
        bus_read(2'b00, rv, roe); check("R11 host write landed", rv, model[5]);
        bus_read(2'b10, rv, roe); check("R11 dev untouched", rv, model[NREG + 1]);

        finish_run();
    end
endmodule